// File: doc/BRIEF.md
# I2C Register Target with SCL-Low Watchdog

This block is the serial side of a register-based peripheral on a two-wire I2C bus. It oversamples the SCL and SDA lines in the system clock domain, passes each through a synchronizer and a majority-free run-length filter, and finds START, STOP and clock edges on the cleaned levels. A protocol engine takes in the address byte, acknowledges its own 7-bit address, and then either writes incoming bytes into an internal register port or fetches register bytes and shifts them out MSB first. A byte pointer is loaded by the first byte of a write and steps after every register access, so a controller can stream any number of bytes between START and STOP.

A watchdog counts system clocks while the filtered SCL is low. If the count reaches the configured limit, the engine drops back to idle, releases SDA and ignores the bus until it sees a new START. Any high level on SCL clears the count, so normal 100 kHz and 400 kHz traffic never trips it.

The block only asks for SDA to be pulled low (`sda_oe`). The open-drain pad and any clock stretching lie outside it. The register storage sits outside the block too: it answers `reg_rdata` combinationally for the address on `reg_addr`.

Top module: `i2ct_target`

## Requirements
- R1: A falling SDA while SCL is high (START) starts a new address phase from any state, including after a timeout. A rising SDA while SCL is high (STOP) returns the engine to idle with `sda_oe` low.
- R2: The first byte after START is received MSB first. Bits 7..1 are the address and bit 0 selects direction (1 = read). A match with `TGT_ADDR` is acknowledged by holding `sda_oe` high through the whole ninth clock. A mismatch is not acknowledged, and later bytes are neither acknowledged nor cause any `reg_we` or `reg_re` until the next START. `sda_oe` only changes while SCL is low.
- R3: In a write, the first data byte loads the pointer and is not written. Each later byte gives a single-cycle `reg_we` with `reg_addr` set to the pointer and `reg_wdata` set to the byte, and the pointer then steps by one. Every data byte is acknowledged.
- R4: In a read, after the address acknowledge, the block fetches the byte at the pointer with a single-cycle `reg_re` and drives it MSB first on SDA, where `sda_oe` high sends a 0. The pointer steps by one after each fetch.
- R5: When the controller acknowledges a read byte (SDA low on the ninth clock), the next byte is fetched and sent. When the controller does not acknowledge (SDA high), the block keeps SDA released, makes no further fetch, and waits for START.
- R6: A repeated START in the middle of a transfer restarts the address phase and keeps the pointer, so a write of the pointer followed by a repeated START and a read returns data from that pointer.
- R7: When filtered SCL stays low for `TMO_CYC` consecutive system clocks, the engine goes idle and releases SDA within one cycle. Later clocks and data are ignored (no acknowledge, no `reg_we`) until a START.
- R8: Any high level on filtered SCL clears the watchdog count, so low periods shorter than `TMO_CYC` never disturb a transfer, whatever the total transfer length.
- R9: A pulse on SCL or SDA lasting fewer than `FILT_LEN` system clocks does not change the filtered level. A data bit pulse on SDA therefore makes no START or STOP, and a short SCL pulse adds no clock edge.
- R10: After reset `sda_oe`, `reg_we` and `reg_re` are low and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr | output | PTR_W | Register pointer presented to the register file |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Byte to be written |
| reg_re | output | 1 | Single-cycle read-fetch strobe |
| reg_rdata | input | 8 | Register byte for `reg_addr`, combinational |

## Verification
Writes use several bytes with mixed bit patterns, including all ones, so a shift or bit-order error shows up as a wrong `reg_wdata` or `reg_addr`. A wrong address tells address matching apart from acknowledging every byte. A pointer write followed by a repeated START and a read that ends in ACK, ACK, NACK separates pointer retention, per-byte stepping and the stop on NACK: extra clocks after the NACK must read all ones. SCL is then held low inside an acknowledge, with slow low periods just under the limit in a separate run, which tells a real timeout from a counter that never clears. Short glitches laid on both lines during a write must leave the written data unchanged.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK
   } eng_st_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } bus_ev_t;

endpackage

// File: rtl/i2ct_line_filter.sv
module i2ct_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end

   assign s_lvl = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt <= 1'b1;
         else        filt <= s_lvl;
      end
   end else begin : g_run
      logic [FILT_LEN-1:0] hist;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist <= '1;
            filt <= 1'b1;
         end else begin
            hist <= {hist[FILT_LEN-2:0], s_lvl};
            if (&hist)       filt <= 1'b1;
            else if (~|hist) filt <= 1'b0;
         end
      end
   end

   // filtered level only moves toward a level the synchronizer already showed
   p_rise_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filt) |-> $past(s_lvl));
   p_fall_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filt) |-> !$past(s_lvl));

endmodule

// File: rtl/i2ct_cond_detect.sv
module i2ct_cond_detect
   import i2ct_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_f,
   input  logic    sda_f,
   output bus_ev_t ev
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   always_comb begin
      ev.start = scl_f & scl_p & sda_p & ~sda_f;
      ev.stop  = scl_f & scl_p & ~sda_p & sda_f;
      ev.rise  = scl_f & ~scl_p;
      ev.fall  = ~scl_f & scl_p;
   end

   p_cond_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.start && ev.stop));
   p_cond_not_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.start || ev.stop) |-> !(ev.rise || ev.fall));

endmodule

// File: rtl/i2ct_scl_watchdog.sv
module i2ct_scl_watchdog #(
   parameter int TMO_CYC = 1750000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   output logic tmo
);

   if (TMO_CYC < 16) begin : g_bad_tmo
      $error("TMO_CYC must be at least 16");
   end

   localparam int CW = $clog2(TMO_CYC + 1);
   localparam logic [CW-1:0] LIMIT   = CW'(TMO_CYC);
   localparam logic [CW-1:0] LAST_LO = CW'(TMO_CYC - 1);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         tmo     <= 1'b0;
      end else begin
         tmo <= 1'b0;
         if (scl_f) begin
            low_cnt <= '0;
         end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
            if (low_cnt == LAST_LO) tmo <= 1'b1;
         end
      end
   end

   p_high_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_f |=> (low_cnt == '0));
   p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !tmo);
   p_tmo_only_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> !$past(scl_f));

endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
   import i2ct_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR    = 7'h2A,
   parameter int         PTR_W       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter int         TMO_CYC     = 1750000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic [PTR_W-1:0]  reg_addr,
   output logic              reg_we,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_re,
   input  logic [BYTE_W-1:0] reg_rdata
);

   if (PTR_W < 1 || PTR_W > 16) begin : g_bad_ptr
      $error("PTR_W must lie in 1..16");
   end

   localparam int N_LINES = 2;
   localparam logic [BIT_CNT_W-1:0] LAST_RX = BIT_CNT_W'(BYTE_W);
   localparam logic [BIT_CNT_W-1:0] LAST_TX = BIT_CNT_W'(BYTE_W - 1);

   // line conditioning: index 0 = SCL, index 1 = SDA
   logic [N_LINES-1:0] raw_lines, filt_lines;
   assign raw_lines = {sda_in, scl_in};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2ct_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_lines[g]),
         .filt  (filt_lines[g])
      );
   end

   logic scl_f, sda_f;
   assign scl_f = filt_lines[0];
   assign sda_f = filt_lines[1];

   bus_ev_t ev;

   i2ct_cond_detect u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (scl_f),
      .sda_f (sda_f),
      .ev    (ev)
   );

   logic tmo;

   i2ct_scl_watchdog #(
      .TMO_CYC (TMO_CYC)
   ) u_wdog (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (scl_f),
      .tmo   (tmo)
   );

   // protocol engine state
   eng_st_t              st;
   logic [BIT_CNT_W-1:0] bit_cnt;
   logic [BYTE_W-1:0]    shreg;
   logic                 addr_phase;
   logic                 ptr_valid;
   logic                 rd_dir;
   logic                 ctl_nack;
   logic [PTR_W-1:0]     ptr;

   logic byte_done, addr_hit, wr_strobe, fetch;

   assign byte_done = (st == ST_RX) && ev.fall && (bit_cnt == LAST_RX);
   assign addr_hit  = (shreg[BYTE_W-1:1] == TGT_ADDR);
   assign wr_strobe = byte_done && !addr_phase && ptr_valid;
   assign fetch     = ev.fall &&
                      (((st == ST_ACK) && rd_dir) ||
                       ((st == ST_TXACK) && !ctl_nack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         addr_phase <= 1'b0;
         ptr_valid  <= 1'b0;
         rd_dir     <= 1'b0;
         ctl_nack   <= 1'b1;
         ptr        <= '0;
         sda_oe     <= 1'b0;
      end else if (tmo) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (ev.start) begin
         st         <= ST_RX;
         bit_cnt    <= '0;
         addr_phase <= 1'b1;
         ptr_valid  <= 1'b0;
         rd_dir     <= 1'b0;
         sda_oe     <= 1'b0;
      end else if (ev.stop) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: ;
            ST_RX: begin
               if (ev.rise && bit_cnt != LAST_RX) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_f};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (byte_done) begin
                  if (addr_phase) begin
                     addr_phase <= 1'b0;
                     if (addr_hit) begin
                        rd_dir <= shreg[0];
                        sda_oe <= 1'b1;
                        st     <= ST_ACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end else begin
                     if (!ptr_valid) begin
                        ptr       <= PTR_W'(shreg);
                        ptr_valid <= 1'b1;
                     end else begin
                        ptr <= ptr + 1'b1;
                     end
                     sda_oe <= 1'b1;
                     st     <= ST_ACK;
                  end
               end
            end
            ST_ACK: begin
               if (ev.fall) begin
                  bit_cnt <= '0;
                  if (rd_dir) begin
                     shreg  <= reg_rdata;
                     sda_oe <= ~reg_rdata[BYTE_W-1];
                     ptr    <= ptr + 1'b1;
                     st     <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (ev.fall) begin
                  if (bit_cnt == LAST_TX) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     st      <= ST_TXACK;
                  end else begin
                     shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                     sda_oe  <= ~shreg[BYTE_W-2];
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_TXACK: begin
               if (ev.rise) begin
                  ctl_nack <= sda_f;
               end else if (ev.fall) begin
                  if (ctl_nack) begin
                     st <= ST_IDLE;
                  end else begin
                     shreg   <= reg_rdata;
                     sda_oe  <= ~reg_rdata[BYTE_W-1];
                     ptr     <= ptr + 1'b1;
                     bit_cnt <= '0;
                     st      <= ST_TX;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign reg_addr  = ptr;
   assign reg_we    = wr_strobe && !tmo && !ev.start && !ev.stop;
   assign reg_wdata = shreg;
   assign reg_re    = fetch && !tmo && !ev.start && !ev.stop;

   p_we_re_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   p_wptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));
   p_rptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));
   p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_f));
   p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> !sda_oe);
   p_tmo_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !sda_oe);
   p_tmo_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> !(reg_we || reg_re));

endmodule

// File: tb/sim_i2ct_target.sv
module sim_i2ct_target;

   localparam int Q   = 25;
   localparam int TMO = 400;
   localparam logic [6:0] ADDR = 7'h2A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1;
   logic scl_glitch = 1'b0, sda_glitch = 1'b0;
   logic sda_oe, reg_we, reg_re;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;

   wire scl_line = scl_drv | scl_glitch;
   wire sda_line = sda_drv & ~sda_oe & ~sda_glitch;

   always #5 clk = ~clk;

   function automatic logic [7:0] rd_model(input logic [7:0] a);
      return a * 8'd37 + 8'd5;
   endfunction

   assign reg_rdata = rd_model(reg_addr);

   i2ct_target #(
      .TGT_ADDR (ADDR),
      .PTR_W    (8),
      .FILT_LEN (3),
      .TMO_CYC  (TMO)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_line),
      .sda_in    (sda_line),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   int checks = 0;
   int fails = 0;
   int wn = 0;
   int rn = 0;
   int low_extra = 0;
   bit glitch_en = 1'b0;
   logic [7:0] wlog_a [32];
   logic [7:0] wlog_d [32];

   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (wn < 32) begin
            wlog_a[wn] = reg_addr;
            wlog_d[wn] = reg_wdata;
         end
         wn++;
      end
      if (rst_n && reg_re) rn++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, output logic rd);
      sda_drv = b;
      wait_clk(Q + low_extra);
      scl_drv = 1'b1;
      wait_clk(Q);
      rd = sda_line;
      if (glitch_en) begin
         sda_glitch = 1'b1;
         wait_clk(2);
         sda_glitch = 1'b0;
         wait_clk(Q - 2);
      end else begin
         wait_clk(Q);
      end
      scl_drv = 1'b0;
      if (glitch_en) begin
         wait_clk(10);
         scl_glitch = 1'b1;
         wait_clk(2);
         scl_glitch = 1'b0;
         wait_clk(Q - 12);
      end else begin
         wait_clk(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic rd;
      for (int i = 7; i >= 0; i--) send_bit(b[i], rd);
      send_bit(1'b1, rd);
      acked = ~rd;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic rd;
      for (int i = 7; i >= 0; i--) begin
         send_bit(1'b1, rd);
         b[i] = rd;
      end
      send_bit(~give_ack, rd);
   endtask

   task automatic bus_start;
      sda_drv = 1'b1;
      wait_clk(Q);
      scl_drv = 1'b1;
      wait_clk(Q);
      sda_drv = 1'b0;
      wait_clk(Q);
      scl_drv = 1'b0;
      wait_clk(Q);
   endtask

   task automatic bus_stop;
      sda_drv = 1'b0;
      wait_clk(Q);
      scl_drv = 1'b1;
      wait_clk(Q);
      sda_drv = 1'b1;
      wait_clk(2 * Q);
   endtask

   task automatic t_reset;
      chk("R10 sda_oe after reset", sda_oe, 0);
      chk("R10 reg_we after reset", reg_we, 0);
      chk("R10 reg_re after reset", reg_re, 0);
      chk("R10 reg_addr after reset", reg_addr, 0);
   endtask

   task automatic t_write;
      logic a;
      int w0;
      w0 = wn;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R2 own address acked", a, 1);
      send_byte(8'h10, a);        chk("R3 pointer byte acked", a, 1);
      chk("R3 pointer byte not written", wn - w0, 0);
      send_byte(8'hA5, a);        chk("R3 data 0 acked", a, 1);
      send_byte(8'h3C, a);        chk("R3 data 1 acked", a, 1);
      send_byte(8'hFF, a);        chk("R3 data 2 acked", a, 1);
      bus_stop();
      chk("R1 sda released after STOP", sda_oe, 0);
      chk("R3 write count", wn - w0, 3);
      chk("R3 write addr 0", wlog_a[w0],     8'h10);
      chk("R3 write data 0", wlog_d[w0],     8'hA5);
      chk("R3 write addr 1", wlog_a[w0 + 1], 8'h11);
      chk("R3 write data 1", wlog_d[w0 + 1], 8'h3C);
      chk("R3 write addr 2", wlog_a[w0 + 2], 8'h12);
      chk("R3 write data 2", wlog_d[w0 + 2], 8'hFF);
   endtask

   task automatic t_bad_addr;
      logic a;
      int w0, r0;
      w0 = wn; r0 = rn;
      bus_start();
      send_byte({7'h2B, 1'b0}, a); chk("R2 foreign address not acked", a, 0);
      send_byte(8'h05, a);         chk("R2 byte after mismatch not acked", a, 0);
      send_byte(8'h66, a);         chk("R2 second byte after mismatch not acked", a, 0);
      bus_stop();
      chk("R2 no write after mismatch", wn - w0, 0);
      chk("R2 no fetch after mismatch", rn - r0, 0);
   endtask

   task automatic t_read;
      logic a;
      logic [7:0] d;
      logic rd;
      logic [7:0] tail;
      int r0;
      r0 = rn;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R6 write address acked", a, 1);
      send_byte(8'h20, a);        chk("R6 pointer acked", a, 1);
      bus_start();
      send_byte({ADDR, 1'b1}, a); chk("R6 read address after repeated START acked", a, 1);
      recv_byte(1'b1, d); chk("R4 read byte 0", d, rd_model(8'h20));
      recv_byte(1'b1, d); chk("R5 read byte 1 after ACK", d, rd_model(8'h21));
      recv_byte(1'b0, d); chk("R5 read byte 2 after ACK", d, rd_model(8'h22));
      for (int i = 7; i >= 0; i--) begin
         send_bit(1'b1, rd);
         tail[i] = rd;
      end
      chk("R5 SDA released after NACK", tail, 8'hFF);
      chk("R5 fetch count stops at NACK", rn - r0, 3);
      chk("R4 pointer after three fetches", reg_addr, 8'h23);
      bus_stop();
   endtask

   task automatic t_timeout;
      logic a, rd;
      int w0;
      w0 = wn;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R7 address acked", a, 1);
      send_byte(8'h40, a);        chk("R7 pointer acked", a, 1);
      for (int i = 7; i >= 0; i--) send_bit(8'h77 >> i, rd);
      chk("R7 ack driven before hold", sda_oe, 1);
      wait_clk(2 * TMO);
      chk("R7 sda released by timeout", sda_oe, 0);
      send_bit(1'b1, rd);
      chk("R7 ninth clock after timeout unacked", rd, 1);
      send_byte(8'h88, a); chk("R7 byte ignored after timeout", a, 0);
      chk("R7 only the pre-timeout write", wn - w0, 1);
      chk("R7 pre-timeout write data", wlog_d[w0], 8'h77);
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R1 START after timeout acked", a, 1);
      send_byte(8'h50, a);
      send_byte(8'h99, a);
      bus_stop();
      chk("R7 recovered write count", wn - w0, 2);
      chk("R7 recovered write addr", wlog_a[w0 + 1], 8'h50);
      chk("R7 recovered write data", wlog_d[w0 + 1], 8'h99);
   endtask

   task automatic t_slow_clock;
      logic a;
      int w0;
      w0 = wn;
      low_extra = TMO - 2 * Q - 50;
      bus_start();
      send_byte({ADDR, 1'b0}, a); chk("R8 slow address acked", a, 1);
      send_byte(8'h60, a);
      send_byte(8'h5A, a);        chk("R8 slow data acked", a, 1);
      send_byte(8'hC3, a);
      bus_stop();
      low_extra = 0;
      chk("R8 slow write count", wn - w0, 2);
      chk("R8 slow write data", wlog_d[w0 + 1], 8'hC3);
   endtask

   task automatic t_glitch;
      logic a;
      int w0;
      w0 = wn;
      bus_start();
      glitch_en = 1'b1;
      send_byte({ADDR, 1'b0}, a); chk("R9 address acked under glitches", a, 1);
      send_byte(8'h70, a);
      send_byte(8'hF7, a);        chk("R9 data acked under glitches", a, 1);
      glitch_en = 1'b0;
      bus_stop();
      chk("R9 glitch write count", wn - w0, 1);
      chk("R9 glitch write addr", wlog_a[w0], 8'h70);
      chk("R9 glitch write data", wlog_d[w0], 8'hF7);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      report();
   end

   initial begin
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(10);
      t_write();
      t_bad_addr();
      t_read();
      t_timeout();
      t_slow_clock();
      t_glitch();
      report();
   end

endmodule